// File: doc/BRIEF.md
# Motion-Vector-Driven Reference Window Fetcher

This block sits in front of a sub-pixel interpolator in a video decoder's motion compensation path. For each prediction block (a 4x4 luma block or a 2x2 chroma block) it receives the integer reference position and the fractional part of the motion vector. From the fractional part it works out the smallest set of reference pixels that the interpolation filter will read. A full-pel block needs only its own footprint. A block that is fractional in one direction needs the filter taps along that direction only. The diagonal quarter positions need a cross-shaped region made of a wide band and a narrow column.

The window is walked row by row, left to right. Every 32-bit word that a row's span touches is read from frame memory over a simple request/response bus. Each word holds four 8-bit pixels, and pixel column `c` sits in byte lane `c mod 4`. Word alignment usually drags in pixels outside the window. The last word fetched for each row is therefore kept in a small direct-mapped store. When a later block needs the same word of the same row, the store supplies it and no memory read is issued. Window pixels go to the interpolator one per cycle, each tagged with its frame coordinates.

Coordinates are unsigned and wrap modulo 2^COORD_W. One block is processed at a time.

Top module: `mv_window_fetcher`

## Requirements
- R1: A luma block whose horizontal and vertical fractions (frac_x[1:0], frac_y[1:0]) are both zero streams exactly the 4x4 pixels at columns x..x+3 and rows y..y+3.
- R2: A luma block with a nonzero horizontal fraction and a zero vertical fraction streams rows y..y+3, each covering columns x-2..x+6 (9 pixels).
- R3: A luma block with a zero horizontal fraction and a nonzero vertical fraction streams rows y-2..y+6, each covering columns x..x+3.
- R4: A luma block with both fractions odd streams rows y-2..y+6. The four rows starting at y+(frac_y==3) cover columns x-2..x+6. The other five rows cover columns x+(frac_x==3) .. x+(frac_x==3)+3.
- R5: Every other luma fraction pair (at least one fraction equal to 2, with both fractions nonzero) streams the full 9x9 region of columns x-2..x+6 and rows y-2..y+6.
- R6: A chroma block (is_chroma=1, 3-bit eighth-pel fractions) streams columns x..x+1+(frac_x!=0) and rows y..y+1+(frac_y!=0).
- R7: Pixels leave in ascending row order and in ascending column order within a row, one per pix_valid cycle. Each carries pix_x and pix_y, and takes its value from byte lane (pix_x mod 4), bits [8*lane+7:8*lane], of the word at word index pix_x>>2 of row pix_y. pix_last marks only the final pixel of the window, and busy drops on the next cycle.
- R8: For each row, the block requests each word index from (first column)>>2 to (last column)>>2 in ascending order, with req_row set to the row, unless R9 supplies that word. No request and no pixel share a cycle.
- R9: The last word read from memory for each row is kept in slot (row mod 16). A later need for the same row and word index is served from that slot without a memory request. A read of a different row mapping to the same slot replaces the entry.
- R10: After reset the block is idle (busy, req_valid and pix_valid all 0) and the retention slots are empty.
- R11: A start pulse while busy is ignored: the running window completes unchanged and no second window follows.
- R12: Once raised, req_valid and its address stay unchanged until a cycle with req_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a window; taken only when idle |
| is_chroma | input | 1 | 1: 2x2 chroma block, 0: 4x4 luma block |
| pos_x | input | COORD_W | Integer reference column of the block |
| pos_y | input | COORD_W | Integer reference row of the block |
| frac_x | input | 3 | Horizontal fraction (luma uses bits [1:0]) |
| frac_y | input | 3 | Vertical fraction (luma uses bits [1:0]) |
| busy | output | 1 | A window is in progress |
| req_valid | output | 1 | Memory word read request |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_row | output | COORD_W | Row of the requested word |
| req_word | output | COORD_W-2 | Word index within the row (column>>2) |
| rsp_valid | input | 1 | Read data is present |
| rsp_data | input | 4*PIX_W | Read word, pixel of lane k in bits [8k+7:8k] |
| pix_valid | output | 1 | A window pixel is presented |
| pix_data | output | PIX_W | Pixel value |
| pix_x | output | COORD_W | Column of the pixel |
| pix_y | output | COORD_W | Row of the pixel |
| pix_last | output | 1 | Final pixel of the window |

## Verification
The hardest situation to reach from the ports is a retention hit, and beyond it an eviction. A hit needs a later block whose rows reuse a word index that an earlier block read last in those rows. An eviction needs a third block whose rows fall on the same slots modulo 16. The stimulus places blocks side by side, so the right-hand word of one block is the left-hand word of the next. It then revisits the same rows after an intervening block sixteen rows lower, and checks request counts worked out by hand against a behavioural retention model. A start pulse raised mid-window checks that nothing changes. Memory acceptance stalls on a fixed pattern, so requests are held across several cycles.

// File: rtl/mvwf_pkg.sv
package mvwf_pkg;

    localparam int PIX_PER_WORD = 4;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_ROW,
        FS_LOOK,
        FS_REQ,
        FS_WAIT,
        FS_EMIT
    } fetch_state_e;

    // Window shape relative to the block's integer position.
    // Rows with index inside [band_lo, band_hi] use the wide span,
    // the remaining rows use the narrow span.
    typedef struct packed {
        logic signed [3:0] row_off;
        logic [3:0]        nrows;
        logic [3:0]        band_lo;
        logic [3:0]        band_hi;
        logic signed [3:0] wide_off;
        logic [3:0]        wide_w;
        logic signed [3:0] nar_off;
        logic [3:0]        nar_w;
    } win_shape_t;

endpackage

// File: rtl/mvwf_wnd_plan.sv
module mvwf_wnd_plan
    import mvwf_pkg::*;
(
    input  logic       is_chroma,
    input  logic [2:0] frac_x,
    input  logic [2:0] frac_y,
    output win_shape_t shape
);

    logic [1:0] lfx;
    logic [1:0] lfy;
    logic       l_hor;
    logic       l_ver;
    logic       c_hor;
    logic       c_ver;
    logic       diag;

    assign lfx   = frac_x[1:0];
    assign lfy   = frac_y[1:0];
    assign l_hor = (lfx != 2'd0);
    assign l_ver = (lfy != 2'd0);
    assign c_hor = (frac_x != 3'd0);
    assign c_ver = (frac_y != 3'd0);
    assign diag  = lfx[0] & lfy[0];

    always_comb begin
        shape          = '0;
        shape.nar_off  = 4'sd0;
        shape.nar_w    = 4'd4;
        if (is_chroma) begin
            shape.row_off  = 4'sd0;
            shape.nrows    = c_ver ? 4'd3 : 4'd2;
            shape.band_lo  = 4'd0;
            shape.band_hi  = c_ver ? 4'd2 : 4'd1;
            shape.wide_off = 4'sd0;
            shape.wide_w   = c_hor ? 4'd3 : 4'd2;
        end else if (!l_hor && !l_ver) begin
            shape.row_off  = 4'sd0;
            shape.nrows    = 4'd4;
            shape.band_lo  = 4'd0;
            shape.band_hi  = 4'd3;
            shape.wide_off = 4'sd0;
            shape.wide_w   = 4'd4;
        end else if (l_hor && !l_ver) begin
            shape.row_off  = 4'sd0;
            shape.nrows    = 4'd4;
            shape.band_lo  = 4'd0;
            shape.band_hi  = 4'd3;
            shape.wide_off = -4'sd2;
            shape.wide_w   = 4'd9;
        end else if (!l_hor && l_ver) begin
            shape.row_off  = -4'sd2;
            shape.nrows    = 4'd9;
            shape.band_lo  = 4'd0;
            shape.band_hi  = 4'd8;
            shape.wide_off = 4'sd0;
            shape.wide_w   = 4'd4;
        end else if (diag) begin
            shape.row_off  = -4'sd2;
            shape.nrows    = 4'd9;
            shape.band_lo  = lfy[1] ? 4'd3 : 4'd2;
            shape.band_hi  = lfy[1] ? 4'd6 : 4'd5;
            shape.wide_off = -4'sd2;
            shape.wide_w   = 4'd9;
            shape.nar_off  = lfx[1] ? 4'sd1 : 4'sd0;
            shape.nar_w    = 4'd4;
        end else begin
            shape.row_off  = -4'sd2;
            shape.nrows    = 4'd9;
            shape.band_lo  = 4'd0;
            shape.band_hi  = 4'd8;
            shape.wide_off = -4'sd2;
            shape.wide_w   = 4'd9;
        end
    end

endmodule

// File: rtl/mvwf_row_span.sv
module mvwf_row_span
    import mvwf_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  win_shape_t         shape,
    input  logic [COORD_W-1:0] base_x,
    input  logic [COORD_W-1:0] base_y,
    input  logic [3:0]         row_i,
    output logic [COORD_W-1:0] cur_row,
    output logic [COORD_W-1:0] col_first,
    output logic [COORD_W-1:0] col_final
);

    localparam int EXT_W = COORD_W - 4;

    logic              in_band;
    logic signed [3:0] c_off;
    logic [3:0]        c_w;
    logic [COORD_W-1:0] row_off_x;
    logic [COORD_W-1:0] c_off_x;

    assign in_band   = (row_i >= shape.band_lo) && (row_i <= shape.band_hi);
    assign c_off     = in_band ? shape.wide_off : shape.nar_off;
    assign c_w       = in_band ? shape.wide_w : shape.nar_w;
    assign row_off_x = {{EXT_W{shape.row_off[3]}}, shape.row_off};
    assign c_off_x   = {{EXT_W{c_off[3]}}, c_off};

    assign cur_row   = base_y + row_off_x + {{EXT_W{1'b0}}, row_i};
    assign col_first = base_x + c_off_x;
    assign col_final = col_first + {{EXT_W{1'b0}}, c_w} - {{(COORD_W-1){1'b0}}, 1'b1};

endmodule

// File: rtl/mvwf_retain_store.sv
module mvwf_retain_store #(
    parameter int COORD_W   = 12,
    parameter int WORD_BITS = 32,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [COORD_W-1:0]   look_row,
    input  logic [COORD_W-3:0]   look_word,
    output logic                 look_hit,
    output logic [WORD_BITS-1:0] look_data,
    input  logic                 wr_en,
    input  logic [COORD_W-1:0]   wr_row,
    input  logic [COORD_W-3:0]   wr_word,
    input  logic [WORD_BITS-1:0] wr_data
);

    localparam int SLOTS = 1 << IDX_W;

    logic                 slot_vld  [SLOTS];
    logic [COORD_W-1:0]   slot_row  [SLOTS];
    logic [COORD_W-3:0]   slot_word [SLOTS];
    logic [WORD_BITS-1:0] slot_data [SLOTS];

    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] wr_idx;

    assign look_idx  = look_row[IDX_W-1:0];
    assign wr_idx    = wr_row[IDX_W-1:0];
    assign look_hit  = slot_vld[look_idx] && (slot_row[look_idx] == look_row)
                       && (slot_word[look_idx] == look_word);
    assign look_data = slot_data[look_idx];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[s] <= 1'b0;
            end else if (wr_en && (wr_idx == s[IDX_W-1:0])) begin
                slot_vld[s] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == s[IDX_W-1:0])) begin
                slot_row[s]  <= wr_row;
                slot_word[s] <= wr_word;
                slot_data[s] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/mv_window_fetcher.sv
module mv_window_fetcher
    import mvwf_pkg::*;
#(
    parameter int COORD_W   = 12,
    parameter int PIX_W     = 8,
    parameter int RET_IDX_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         is_chroma,
    input  logic [COORD_W-1:0]           pos_x,
    input  logic [COORD_W-1:0]           pos_y,
    input  logic [2:0]                   frac_x,
    input  logic [2:0]                   frac_y,
    output logic                         busy,
    output logic                         req_valid,
    input  logic                         req_ready,
    output logic [COORD_W-1:0]           req_row,
    output logic [COORD_W-3:0]           req_word,
    input  logic                         rsp_valid,
    input  logic [PIX_PER_WORD*PIX_W-1:0] rsp_data,
    output logic                         pix_valid,
    output logic [PIX_W-1:0]             pix_data,
    output logic [COORD_W-1:0]           pix_x,
    output logic [COORD_W-1:0]           pix_y,
    output logic                         pix_last
);

    localparam int WORD_BITS = PIX_PER_WORD * PIX_W;

    typedef struct packed {
        fetch_state_e         state;
        logic [COORD_W-1:0]   base_x;
        logic [COORD_W-1:0]   base_y;
        win_shape_t           shape;
        logic [3:0]           row_i;
        logic [COORD_W-1:0]   col;
        logic [COORD_W-1:0]   col_end;
        logic [WORD_BITS-1:0] data;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    win_shape_t         plan_shape;
    logic [COORD_W-1:0] span_row;
    logic [COORD_W-1:0] span_first;
    logic [COORD_W-1:0] span_final;
    logic               ret_hit;
    logic [WORD_BITS-1:0] ret_data;
    logic               ret_we;
    logic               row_is_last;
    logic               col_is_last;
    logic [PIX_W-1:0]   lanes [PIX_PER_WORD];

    mvwf_wnd_plan u_plan (
        .is_chroma (is_chroma),
        .frac_x    (frac_x),
        .frac_y    (frac_y),
        .shape     (plan_shape)
    );

    mvwf_row_span #(.COORD_W(COORD_W)) u_span (
        .shape     (ctl_q.shape),
        .base_x    (ctl_q.base_x),
        .base_y    (ctl_q.base_y),
        .row_i     (ctl_q.row_i),
        .cur_row   (span_row),
        .col_first (span_first),
        .col_final (span_final)
    );

    mvwf_retain_store #(
        .COORD_W   (COORD_W),
        .WORD_BITS (WORD_BITS),
        .IDX_W     (RET_IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_row  (span_row),
        .look_word (ctl_q.col[COORD_W-1:2]),
        .look_hit  (ret_hit),
        .look_data (ret_data),
        .wr_en     (ret_we),
        .wr_row    (span_row),
        .wr_word   (ctl_q.col[COORD_W-1:2]),
        .wr_data   (rsp_data)
    );

    assign row_is_last = (ctl_q.row_i == (ctl_q.shape.nrows - 4'd1));
    assign col_is_last = (ctl_q.col == ctl_q.col_end);

    for (genvar g = 0; g < PIX_PER_WORD; g++) begin : g_lane
        assign lanes[g] = ctl_q.data[g*PIX_W +: PIX_W];
    end

    always_comb begin
        ctl_d  = ctl_q;
        ret_we = 1'b0;
        case (ctl_q.state)
            FS_IDLE: begin
                if (start) begin
                    ctl_d.base_x = pos_x;
                    ctl_d.base_y = pos_y;
                    ctl_d.shape  = plan_shape;
                    ctl_d.row_i  = 4'd0;
                    ctl_d.state  = FS_ROW;
                end
            end
            FS_ROW: begin
                ctl_d.col     = span_first;
                ctl_d.col_end = span_final;
                ctl_d.state   = FS_LOOK;
            end
            FS_LOOK: begin
                if (ret_hit) begin
                    ctl_d.data  = ret_data;
                    ctl_d.state = FS_EMIT;
                end else begin
                    ctl_d.state = FS_REQ;
                end
            end
            FS_REQ: begin
                if (req_ready) begin
                    ctl_d.state = FS_WAIT;
                end
            end
            FS_WAIT: begin
                if (rsp_valid) begin
                    ctl_d.data  = rsp_data;
                    ret_we      = 1'b1;
                    ctl_d.state = FS_EMIT;
                end
            end
            FS_EMIT: begin
                if (col_is_last) begin
                    if (row_is_last) begin
                        ctl_d.state = FS_IDLE;
                    end else begin
                        ctl_d.row_i = ctl_q.row_i + 4'd1;
                        ctl_d.state = FS_ROW;
                    end
                end else begin
                    ctl_d.col = ctl_q.col + {{(COORD_W-1){1'b0}}, 1'b1};
                    if (ctl_q.col[1:0] == 2'd3) begin
                        ctl_d.state = FS_LOOK;
                    end
                end
            end
            default: ctl_d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.state != FS_IDLE);
    assign req_valid = (ctl_q.state == FS_REQ);
    assign req_row   = span_row;
    assign req_word  = ctl_q.col[COORD_W-1:2];
    assign pix_valid = (ctl_q.state == FS_EMIT);
    assign pix_data  = lanes[ctl_q.col[1:0]];
    assign pix_x     = ctl_q.col;
    assign pix_y     = span_row;
    assign pix_last  = pix_valid && col_is_last && row_is_last;

endmodule

// File: rtl/mvwf_chk.sv
module mvwf_chk #(
    parameter int COORD_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               req_valid,
    input logic               req_ready,
    input logic [COORD_W-1:0] req_row,
    input logic [COORD_W-3:0] req_word,
    input logic               pix_valid,
    input logic               pix_last
);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_row) && $stable(req_word)));

    // R8
    req_pix_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && pix_valid));

    // R7
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_last |=> !busy);

    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_last |-> pix_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!req_valid && !pix_valid));

endmodule

bind mv_window_fetcher mvwf_chk #(.COORD_W(COORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_row   (req_row),
    .req_word  (req_word),
    .pix_valid (pix_valid),
    .pix_last  (pix_last)
);

// File: tb/mv_window_fetcher_tb.sv
`timescale 1ns/1ps
module mv_window_fetcher_tb;

    localparam int CW = 12;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          is_chroma = 1'b0;
    logic [CW-1:0] pos_x = '0;
    logic [CW-1:0] pos_y = '0;
    logic [2:0]    frac_x = '0;
    logic [2:0]    frac_y = '0;
    logic          busy;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [CW-1:0] req_row;
    logic [CW-3:0] req_word;
    logic          rsp_valid = 1'b0;
    logic [31:0]   rsp_data = '0;
    logic          pix_valid;
    logic [PW-1:0] pix_data;
    logic [CW-1:0] pix_x;
    logic [CW-1:0] pix_y;
    logic          pix_last;

    always #2 clk = ~clk;

    mv_window_fetcher #(.COORD_W(CW), .PIX_W(PW), .RET_IDX_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_chroma(is_chroma),
        .pos_x(pos_x), .pos_y(pos_y), .frac_x(frac_x), .frac_y(frac_y),
        .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_word(req_word), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_x(pix_x), .pix_y(pix_y), .pix_last(pix_last)
    );

    typedef struct {
        int x;
        int y;
        int v;
        bit last;
    } exp_pix_t;

    exp_pix_t exp_pix[$];
    int       exp_rrow[$];
    int       exp_rword[$];
    int       errors = 0;
    int       checks = 0;
    int       pix_n = 0;
    int       req_n = 0;
    int       cyc = 0;
    int       pend = 0;
    int       p_row = 0;
    int       p_word = 0;
    string    cur_tag = "R10";
    bit       m_vld [16];
    int       m_row [16];
    int       m_word [16];
    bit       done = 1'b0;

    function automatic int memval(int row, int col);
        return (row * 29 + col * 11 + 5) & 255;
    endfunction

    function automatic logic [31:0] word_of(int row, int word);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[k*8 +: 8] = memval(row, word * 4 + k);
        return w;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural window model: builds the expected pixel and request lists.
    task automatic model_block(bit ch, int x, int y, int fx, int fy);
        int top, rows;
        for (int i = 0; i < 16; i++) begin
            int row, cs, w;
            bit hor, ver;
            if (ch) begin
                top = y; rows = (fy != 0) ? 3 : 2;
                if (i >= rows) break;
                row = top + i; cs = x; w = (fx != 0) ? 3 : 2;
            end else begin
                hor = (fx != 0); ver = (fy != 0);
                top  = ver ? y - 2 : y;
                rows = ver ? 9 : 4;
                if (i >= rows) break;
                row = top + i;
                if (!hor) begin
                    cs = x; w = 4;
                end else if (!ver) begin
                    cs = x - 2; w = 9;
                end else if ((fx % 2 == 1) && (fy % 2 == 1)) begin
                    int band_top;
                    band_top = y + ((fy == 3) ? 1 : 0);
                    if (row >= band_top && row <= band_top + 3) begin
                        cs = x - 2; w = 9;
                    end else begin
                        cs = x + ((fx == 3) ? 1 : 0); w = 4;
                    end
                end else begin
                    cs = x - 2; w = 9;
                end
            end
            for (int c = cs; c < cs + w; c++) begin
                exp_pix_t e;
                if (c == cs || (c % 4) == 0) begin
                    int slot;
                    slot = row % 16;
                    if (!(m_vld[slot] && m_row[slot] == row && m_word[slot] == c / 4)) begin
                        exp_rrow.push_back(row);
                        exp_rword.push_back(c / 4);
                        m_vld[slot] = 1'b1;
                        m_row[slot] = row;
                        m_word[slot] = c / 4;
                    end
                end
                e.x = c; e.y = row; e.v = memval(row, c);
                e.last = (i == rows - 1) && (c == cs + w - 1);
                exp_pix.push_back(e);
            end
        end
    endtask

    // Memory responder and output monitor, evaluated away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            rsp_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data = word_of(p_row, p_word);
                end
            end
            req_ready = ((cyc % 3) != 1);
            if (rst_n && req_valid && req_ready) begin
                req_n++;
                if (exp_rrow.size() == 0) begin
                    chk(1'b0, cur_tag, "R8 unexpected request row", int'(req_row), -1);
                end else begin
                    int er, ew;
                    er = exp_rrow.pop_front();
                    ew = exp_rword.pop_front();
                    chk(int'(req_row) == er, cur_tag, "R8 request row", int'(req_row), er);
                    chk(int'(req_word) == ew, cur_tag, "R8 request word", int'(req_word), ew);
                end
                p_row = int'(req_row);
                p_word = int'(req_word);
                pend = 2;
            end
            if (rst_n && pix_valid) begin
                pix_n++;
                if (exp_pix.size() == 0) begin
                    chk(1'b0, cur_tag, "R7 unexpected pixel x", int'(pix_x), -1);
                end else begin
                    exp_pix_t e;
                    e = exp_pix.pop_front();
                    chk(int'(pix_x) == e.x && int'(pix_y) == e.y, cur_tag, "R7 pixel coordinate",
                        int'(pix_y) * 4096 + int'(pix_x), e.y * 4096 + e.x);
                    chk(int'(pix_data) == e.v, cur_tag, "R7 pixel lane value", int'(pix_data), e.v);
                    chk(pix_last == e.last, cur_tag, "R7 last flag", int'(pix_last), int'(e.last));
                end
            end
        end
    end

    task automatic run_block(bit ch, int x, int y, int fx, int fy, int n_pix, int n_req,
                             string tag, bit poke);
        int guard;
        cur_tag = tag;
        model_block(ch, x, y, fx, fy);
        pix_n = 0;
        req_n = 0;
        @(negedge clk);
        start = 1'b1; is_chroma = ch; pos_x = CW'(x); pos_y = CW'(y);
        frac_x = 3'(fx); frac_y = 3'(fy);
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (busy && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (poke && guard == 20) begin
                // R11: a start pulse in mid-window with other parameters
                start = 1'b1; is_chroma = ~ch; pos_x = CW'(x + 100); frac_x = 3'd2; frac_y = 3'd2;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(guard < 4000, tag, "watchdog window end", guard, 4000);
        repeat (6) @(negedge clk);
        chk(!busy, tag, "idle after window", int'(busy), 0);
        chk(pix_n == n_pix, tag, "pixel count", pix_n, n_pix);
        if (n_req >= 0) chk(req_n == n_req, tag, "request count", req_n, n_req);
        chk(exp_pix.size() == 0, tag, "pixels left unsent", exp_pix.size(), 0);
        chk(exp_rrow.size() == 0, tag, "requests left unsent", exp_rrow.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(!busy && !req_valid && !pix_valid, "R10", "idle outputs under reset",
            int'({busy, req_valid, pix_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !req_valid && !pix_valid, "R10", "idle outputs after reset",
            int'({busy, req_valid, pix_valid}), 0);

        run_block(1'b0, 5, 3, 0, 0, 16, 8, "R1", 1'b0);
        run_block(1'b0, 9, 3, 0, 0, 16, 4, "R9", 1'b0);
        run_block(1'b0, 20, 10, 2, 0, 36, 12, "R2", 1'b0);
        run_block(1'b0, 33, 40, 0, 1, 36, 18, "R3", 1'b0);
        run_block(1'b0, 50, 60, 1, 1, 56, 22, "R4", 1'b0);
        run_block(1'b0, 70, 80, 3, 3, 56, 22, "R4", 1'b0);
        run_block(1'b0, 90, 20, 3, 1, 56, -1, "R4", 1'b0);
        run_block(1'b0, 100, 100, 2, 1, 81, 27, "R5", 1'b0);
        run_block(1'b1, 8, 8, 0, 0, 4, 2, "R6", 1'b0);
        run_block(1'b1, 13, 9, 5, 3, 9, 3, "R6", 1'b0);
        run_block(1'b1, 30, 2, 0, 4, 6, 3, "R6", 1'b0);
        run_block(1'b1, 14, 9, 0, 0, 4, 0, "R9", 1'b0);
        run_block(1'b0, 5, 19, 0, 0, 16, 8, "R9", 1'b0);
        run_block(1'b0, 9, 3, 0, 0, 16, 8, "R9", 1'b0);
        run_block(1'b0, 40, 40, 0, 0, 16, 4, "R11", 1'b1);
        run_block(1'b0, 200, 300, 2, 2, 81, -1, "R12", 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule